// File: doc/BRIEF.md
# Line Control Register with Extended Bank Unlock

This block holds a serial port's line control register and the gate that decides which registers a small 8-bit processor bus can reach. The bus has a 3-bit address, a write strobe, a read strobe, write data and read data. The line control register stores seven data-format bits and a top access bit. When the top bit is set, the divisor latches appear at offsets 0 and 1.

Writing a reserved key value (0xBF) to the line control register does not select a data format. It sets only the access bit, keeps the stored format bits unchanged and opens a hidden bank. That bank holds the enhanced-feature register and four flow-control characters: two XON values and two XOFF values. Any other value written to the line control register closes the bank and is stored whole. A FIFO-depth control bit sits at offset 2 outside the hidden bank. Its writability depends on an external FIFO-select pin, on the enhanced-mode bit and on the access bit.

The registers are brought out on ports so that the serial logic around the block can use them. The bus interface is a plain register port with no back-pressure: a write completes on the clock edge where the write strobe is high, and read data is combinational while the read strobe is high.

Top module: `lcr_bank_unlock`

## Requirements
- R1: After the active-low synchronous reset, every register is 0. Every offset reads 0, and the format, divisor, enhanced-feature, flow-character and depth outputs are 0.
- R2: A write of any value other than 0xBF to offset 3 stores all 8 bits. A read of offset 3 returns the access bit in bit 7 and the format bits in bits 6:0.
- R3: A write of 0xBF to offset 3 sets bit 7 and leaves bits 6:0 at their previous values.
- R4: After a 0xBF write, the bank is open. Offset 2 reads and writes the enhanced-feature register, and offsets 4, 5, 6 and 7 read and write flow characters 0 to 3 (XON1, XON2, XOFF1, XOFF2).
- R5: When bit 7 was set by a value other than 0xBF, offsets 4 to 7 read 0 and writes to them leave the flow characters unchanged.
- R6: A non-key write to offset 3 closes the bank. The hidden registers keep their values but read 0 at offsets 4 to 7, and writes to those offsets are ignored.
- R7: While bit 7 is set, offset 0 is the divisor low byte and offset 1 is the divisor high byte. While bit 7 is clear, those offsets read 0 and writes to them leave the divisor unchanged.
- R8: Outside the open bank, a write to offset 2 loads data bit 5 into the FIFO-depth bit in two cases: the enhanced-mode bit (enhanced-feature register bit 4) is 1, or the FIFO-select pin is low. When enhanced mode is off and the pin is high, the depth bit loads only while bit 7 is set.
- R9: Outside the open bank, a read of offset 2 returns the depth bit in bit 5 and zeros elsewhere.
- R10: While the read strobe is low, read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| fifo_sel | input | 1 | FIFO-select pin; high gates the depth bit on the access bit |
| line_fmt | output | 7 | Stored data-format bits |
| div_access | output | 1 | Access bit (line control bit 7) |
| bank_open | output | 1 | Hidden bank is open |
| divisor | output | 16 | Baud divisor, high byte then low byte |
| enh_feat | output | 8 | Enhanced-feature register |
| flow_chars | output | 32 | Flow characters; character i in bits 8i+7:8i |
| deep_fifo | output | 1 | FIFO-depth control bit |

## Verification
The bench uses the default parameters: 8-bit data, the key 0xBF, enhanced-mode bit 4, depth bit 5 and four flow characters at offsets 4 to 7. This covers the full 3-bit address space, so every offset can be reached in each of the three access modes. Random writes to offset 3 include the key about one time in four. This makes mode changes frequent, and writes to the divisor, depth and hidden offsets land while they are both reachable and gated off. A toggling FIFO-select pin reaches all four cases of the depth-bit gate.

// File: rtl/lcr_bank_pkg.sv
package lcr_bank_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_DIVISOR  = 2'd1,
    MODE_EXTENDED = 2'd2
  } access_mode_e;

  localparam logic [AW-1:0] OFF_DIV_LO = 3'd0;
  localparam logic [AW-1:0] OFF_DIV_HI = 3'd1;
  localparam logic [AW-1:0] OFF_CTL    = 3'd2;
  localparam logic [AW-1:0] OFF_LINE   = 3'd3;
  localparam int            FC_BASE    = 4;
endpackage

// File: rtl/lcr_gate.sv
module lcr_gate
  import lcr_bank_pkg::*;
#(
  parameter int              W   = DW,
  parameter logic [W-1:0]    KEY = 8'hBF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_we,
  input  logic [W-1:0]       wdata,
  output logic [W-2:0]       fmt,
  output logic               dlab,
  output logic               open_q,
  output access_mode_e       mode
);
  logic key_hit;
  assign key_hit = (wdata == KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt    <= '0;
      dlab   <= 1'b0;
      open_q <= 1'b0;
    end else if (line_we) begin
      if (key_hit) begin
        dlab   <= 1'b1;
        open_q <= 1'b1;
      end else begin
        fmt    <= wdata[W-2:0];
        dlab   <= wdata[W-1];
        open_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (open_q)    mode = MODE_EXTENDED;
    else if (dlab) mode = MODE_DIVISOR;
    else           mode = MODE_NORMAL;
  end

  // R3
  key_keeps_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && key_hit) |=> (dlab && open_q && fmt == $past(fmt)));

  // R6
  exit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && !key_hit) |=> !open_q);
endmodule

// File: rtl/lcr_ext_regs.sv
module lcr_ext_regs
  import lcr_bank_pkg::*;
#(
  parameter int W         = DW,
  parameter int A         = AW,
  parameter int NUM_FC    = 4,
  parameter int ENH_BIT   = 4,
  parameter int DEPTH_BIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  access_mode_e       mode,
  input  logic               wr,
  input  logic [A-1:0]       addr,
  input  logic [W-1:0]       wdata,
  input  logic               fifo_sel,
  output logic [2*W-1:0]     divisor,
  output logic [W-1:0]       efr,
  output logic [NUM_FC*W-1:0] fc,
  output logic               deep
);
  logic div_lo_we, div_hi_we, efr_we, ctl_we, depth_open;

  assign div_lo_we  = wr && (addr == OFF_DIV_LO) && (mode != MODE_NORMAL);
  assign div_hi_we  = wr && (addr == OFF_DIV_HI) && (mode != MODE_NORMAL);
  assign efr_we     = wr && (addr == OFF_CTL) && (mode == MODE_EXTENDED);
  assign ctl_we     = wr && (addr == OFF_CTL) && (mode != MODE_EXTENDED);
  assign depth_open = efr[ENH_BIT] || !fifo_sel || (mode == MODE_DIVISOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor <= '0;
      efr     <= '0;
      deep    <= 1'b0;
    end else begin
      if (div_lo_we) divisor[W-1:0]   <= wdata;
      if (div_hi_we) divisor[2*W-1:W] <= wdata;
      if (efr_we)    efr              <= wdata;
      if (ctl_we && depth_open) deep  <= wdata[DEPTH_BIT];
    end
  end

  for (genvar i = 0; i < NUM_FC; i++) begin : g_fc
    logic fc_we;
    assign fc_we = wr && (int'(addr) == FC_BASE + i) && (mode == MODE_EXTENDED);
    always_ff @(posedge clk) begin
      if (!rst_n)     fc[i*W +: W] <= '0;
      else if (fc_we) fc[i*W +: W] <= wdata;
    end
  end

  // R5
  hidden_fc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode != MODE_EXTENDED && int'(addr) >= FC_BASE) |=> (fc == $past(fc)));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode == MODE_NORMAL && (addr == OFF_DIV_LO || addr == OFF_DIV_HI))
    |=> (divisor == $past(divisor)));

  // R8
  depth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_CTL && mode == MODE_NORMAL && fifo_sel && !efr[ENH_BIT])
    |=> (deep == $past(deep)));
endmodule

// File: rtl/lcr_bank_unlock.sv
module lcr_bank_unlock
  import lcr_bank_pkg::*;
#(
  parameter int NUM_FC    = 4,
  parameter int ENH_BIT   = 4,
  parameter int DEPTH_BIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               fifo_sel,
  output logic [DW-2:0]      line_fmt,
  output logic               div_access,
  output logic               bank_open,
  output logic [2*DW-1:0]    divisor,
  output logic [DW-1:0]      enh_feat,
  output logic [NUM_FC*DW-1:0] flow_chars,
  output logic               deep_fifo
);
  access_mode_e mode;
  logic         line_we;
  logic [DW-1:0] ctl_view;

  assign line_we = bus_wr && (bus_addr == OFF_LINE);

  lcr_gate #(.W(DW), .KEY(8'hBF)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_we(line_we),
    .wdata  (bus_wdata),
    .fmt    (line_fmt),
    .dlab   (div_access),
    .open_q (bank_open),
    .mode   (mode)
  );

  lcr_ext_regs #(
    .W(DW), .A(AW), .NUM_FC(NUM_FC), .ENH_BIT(ENH_BIT), .DEPTH_BIT(DEPTH_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .fifo_sel(fifo_sel),
    .divisor (divisor),
    .efr     (enh_feat),
    .fc      (flow_chars),
    .deep    (deep_fifo)
  );

  always_comb begin
    ctl_view = '0;
    ctl_view[DEPTH_BIT] = deep_fifo;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFF_DIV_LO: if (mode != MODE_NORMAL) bus_rdata = divisor[DW-1:0];
        OFF_DIV_HI: if (mode != MODE_NORMAL) bus_rdata = divisor[2*DW-1:DW];
        OFF_CTL:    bus_rdata = (mode == MODE_EXTENDED) ? enh_feat : ctl_view;
        OFF_LINE:   bus_rdata = {div_access, line_fmt};
        default: begin
          for (int i = 0; i < NUM_FC; i++)
            if (int'(bus_addr) == FC_BASE + i && mode == MODE_EXTENDED)
              bus_rdata = flow_chars[i*DW +: DW];
        end
      endcase
    end
  end

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/test_lcr_bank_unlock.sv
module test_lcr_bank_unlock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic fifo_sel = 1'b1;
  logic [6:0] line_fmt;
  logic div_access, bank_open, deep_fifo;
  logic [15:0] divisor;
  logic [7:0] enh_feat;
  logic [31:0] flow_chars;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // model
  logic [6:0] m_fmt; logic m_dlab, m_open, m_deep;
  logic [15:0] m_div; logic [7:0] m_efr; logic [7:0] m_fc [4];

  always #4 clk = ~clk;

  lcr_bank_unlock i_lcr_bank_unlock (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_sel(fifo_sel), .line_fmt(line_fmt), .div_access(div_access),
    .bank_open(bank_open), .divisor(divisor), .enh_feat(enh_feat),
    .flow_chars(flow_chars), .deep_fifo(deep_fifo)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a);
    logic [7:0] d = '0;
    case (a)
      3'd0: if (m_dlab) d = m_div[7:0];
      3'd1: if (m_dlab) d = m_div[15:8];
      3'd2: d = m_open ? m_efr : {2'b00, m_deep, 5'b0};
      3'd3: d = {m_dlab, m_fmt};
      default: if (m_open) d = m_fc[a - 3'd4];
    endcase
    return d;
  endfunction

  function automatic string req_of(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R7";
      3'd2: return m_open ? "R4" : "R9";
      3'd3: return "R2";
      default: return m_open ? "R4" : "R6";
    endcase
  endfunction

  task automatic model_reset();
    m_fmt = '0; m_dlab = 0; m_open = 0; m_deep = 0; m_div = '0; m_efr = '0;
    for (int i = 0; i < 4; i++) m_fc[i] = '0;
  endtask

  task automatic model_write(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: if (m_dlab) m_div[7:0] = d;
      3'd1: if (m_dlab) m_div[15:8] = d;
      3'd2: if (m_open) m_efr = d;
            else if (m_efr[4] || !fifo_sel || m_dlab) m_deep = d[5];
      3'd3: if (d == 8'hBF) begin m_dlab = 1; m_open = 1; end
            else begin m_fmt = d[6:0]; m_dlab = d[7]; m_open = 0; end
      default: if (m_open) m_fc[a - 3'd4] = d;
    endcase
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(logic [2:0] a, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, {24'b0, bus_rdata}, {24'b0, exp_read(a)});
    bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1");
    check("R1", {line_fmt, div_access, deep_fifo, enh_feat}, '0);
    check("R1", {divisor, 16'b0}, '0);
    check("R1", flow_chars, '0);
    // R2 normal store
    wr(3, 8'h1B); rd_chk(3, "R2");
    // R7 divisor hidden while bit 7 clear
    wr(0, 8'h55); check("R7", {16'b0, divisor}, 32'h0); rd_chk(0, "R7");
    // R7 divisor mode
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
    check("R7", {16'b0, divisor}, 32'h1234); rd_chk(1, "R7");
    // R5 hidden bank stays closed
    wr(4, 8'h11); check("R5", flow_chars, 32'h0); rd_chk(4, "R5");
    // R8 depth bit gated
    fifo_sel = 1'b1; wr(2, 8'h20); check("R8", {31'b0, deep_fifo}, 32'd1);
    wr(3, 8'h03); wr(2, 8'h00); check("R8", {31'b0, deep_fifo}, 32'd1);
    fifo_sel = 1'b0; wr(2, 8'h00); check("R8", {31'b0, deep_fifo}, 32'd0);
    rd_chk(2, "R9");
    // R3 key write
    wr(3, 8'hBF);
    check("R3", {24'b0, div_access, line_fmt}, 32'h83); rd_chk(3, "R3");
    check("R4", {31'b0, bank_open}, 32'd1);
    // R4 hidden bank access
    wr(2, 8'h10); wr(4, 8'h11); wr(5, 8'h13); wr(6, 8'h91); wr(7, 8'h93);
    for (int a = 4; a < 8; a++) rd_chk(3'(a), "R4");
    rd_chk(2, "R4"); check("R4", flow_chars, 32'h9391_1311);
    // R6 exit
    wr(3, 8'h07); check("R6", {31'b0, bank_open}, 32'd0);
    wr(5, 8'hEE); check("R6", flow_chars, 32'h9391_1311);
    rd_chk(5, "R6"); rd_chk(2, "R9");
    // R8 enhanced bit opens depth with pin high
    fifo_sel = 1'b1; wr(2, 8'h20); check("R8", {31'b0, deep_fifo}, 32'd1);
    // R10 idle read
    @(negedge clk); bus_addr = 3; #1;
    check("R10", {24'b0, bus_rdata}, 32'h0);
    // random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3 && $urandom_range(0, 3) == 0) d = 8'hBF;
      fifo_sel = 1'($urandom);
      wr(a, d);
      rd_chk(3'($urandom_range(0, 7)), "R2");
      if (n % 20 == 0)
        for (int b = 0; b < 8; b++) rd_chk(3'(b), req_of(3'(b)));
    end
    check("R7", {16'b0, divisor}, {16'b0, m_div});
    check("R8", {31'b0, deep_fifo}, {31'b0, m_deep});
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule